// File: doc/BRIEF.md
# Gated On-Delay Timer

This block is a single-channel on-delay timer. Time advances only on cycles where the clock-enable tick input is high. A rising edge on the start input begins a timing period whose length is a preset number of ticks. When the period has elapsed, the output either drives a pulse of programmable width or, if that width is zero, stays on until it is cleared. While the gate input is high, timing is suspended. A reset request clears the timer only once it has stayed high for a programmable number of ticks. While the reset request is high, no new period can begin.

The present value is available as a port. It shows either the elapsed tick count or the remaining tick count, chosen by a mode input. A running flag is also provided. The period length, the pulse width and the reset width are captured when a period starts. All control inputs are assumed to be synchronous to the clock already. The asynchronous reset of the block stands in for loss of power.

Top module: `on_delay_timer`

## Requirements
- R1: A rising edge of start_i seen in the idle state, with reset_i low, sets running_o in the cycle that follows.
- R2: Once started with a period length of 1 or more, out_o turns on after exactly period-length counting ticks. A counting tick is a tick_i cycle with gate_i low.
- R3: With a pulse width N greater than 0, out_o stays high for exactly N ticks. The block then returns to idle, with running_o low and an up-mode present value of 0.
- R4: With a pulse width of 0, out_o stays high until a qualified reset or rst_ni clears it.
- R5: When count_down_i is 0, pv_o shows the elapsed ticks of the current period. When count_down_i is 1, pv_o shows the period length minus the elapsed ticks.
- R6: While gate_i is high, the elapsed count is held. Counting continues from the held value once gate_i falls.
- R7: A reset_i held for at least the captured reset width in ticks turns out_o off, ends any period and returns the present value to its start value.
- R8: A reset_i pulse shorter than the captured reset width has no effect on out_o or on the period.
- R9: A start rising edge while reset_i is high does not begin a period.
- R10: A start rising edge while a period or an output is active is ignored. A falling edge of start_i has no effect.
- R11: Changes to period_i, width_i or rst_width_i after a start do not alter the period in progress.
- R12: rst_ni low at once clears out_o, running_o and the present value.
- R13: On cycles with tick_i low, the elapsed count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power loss) |
| tick_i | input | 1 | Clock-enable time base |
| start_i | input | 1 | Start request, rising-edge triggered |
| gate_i | input | 1 | Pause timing while high |
| reset_i | input | 1 | Width-qualified timer clear |
| count_down_i | input | 1 | Present value mode: 0 elapsed, 1 remaining |
| period_i | input | CNT_W | Period length in ticks |
| width_i | input | CNT_W | Output pulse width in ticks, 0 latches |
| rst_width_i | input | RW_W | Minimum reset_i width in ticks |
| pv_o | output | CNT_W | Present value |
| running_o | output | 1 | Period in progress |
| out_o | output | 1 | Timer output |

## Verification
The assertions assume that every control input is already synchronous to clk_i and changes only between clock edges. They also assume that a started period has a length of at least one tick, because a zero length has no meaningful elapsed count. The bench changes all inputs on the falling clock edge. It always programs period lengths of three or more ticks, so that gate and start events placed in the middle of a run land while the period is still active. The reset width stays constant between starts, so the width in force is always known.

// File: rtl/odt_pkg.sv
package odt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PULSE = 2'd2,
    ST_HOLD  = 2'd3
  } tmr_state_e;
endpackage

// File: rtl/edge_rise.sv
module edge_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/rst_width_filter.sv
module rst_width_filter #(
  parameter int RW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            req_i,
  input  logic [RW_W-1:0] min_w_i,
  output logic            fire_o
);
  logic [RW_W-1:0] held_q;

  // counts ticks of continuous request, saturating at the required width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         held_q <= '0;
    else if (!req_i)                     held_q <= '0;
    else if (tick_i && held_q < min_w_i) held_q <= held_q + 1'b1;
  end

  assign fire_o = req_i && (held_q >= min_w_i);

  assert_short_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_i) && min_w_i != '0) |-> !fire_o);
endmodule

// File: rtl/on_delay_timer.sv
module on_delay_timer #(
  parameter int CNT_W = 16,
  parameter int RW_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             gate_i,
  input  logic             reset_i,
  input  logic             count_down_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [RW_W-1:0]  rst_width_i,
  output logic [CNT_W-1:0] pv_o,
  output logic             running_o,
  output logic             out_o
);
  import odt_pkg::*;

  localparam logic [CNT_W:0] ONE_X = (CNT_W+1)'(1);

  tmr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, ocnt_q, ocnt_d;
  logic [CNT_W-1:0] sv_q, sv_d, tout_q, tout_d;
  logic [RW_W-1:0]  rtsr_q, rtsr_d;
  logic [CNT_W:0]   cnt_nx, ocnt_nx;
  logic             start_rise, rst_ok;

  edge_rise u_start_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (start_i),
    .rise_o (start_rise)
  );

  rst_width_filter #(.RW_W(RW_W)) u_rst_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .req_i   (reset_i),
    .min_w_i (rtsr_q),
    .fire_o  (rst_ok)
  );

  assign cnt_nx  = {1'b0, cnt_q} + ONE_X;
  assign ocnt_nx = {1'b0, ocnt_q} + ONE_X;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ocnt_d  = ocnt_q;
    sv_d    = sv_q;
    tout_d  = tout_q;
    rtsr_d  = rtsr_q;
    if (rst_ok) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      ocnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_rise && !reset_i) begin
            state_d = ST_RUN;
            cnt_d   = '0;
            sv_d    = period_i;
            tout_d  = width_i;
            rtsr_d  = rst_width_i;
          end
        end
        ST_RUN: begin
          if (tick_i && !gate_i) begin
            if (cnt_nx >= {1'b0, sv_q}) begin
              cnt_d   = sv_q;
              ocnt_d  = '0;
              state_d = (tout_q == '0) ? ST_HOLD : ST_PULSE;
            end else begin
              cnt_d = cnt_nx[CNT_W-1:0];
            end
          end
        end
        ST_PULSE: begin
          if (tick_i) begin
            if (ocnt_nx >= {1'b0, tout_q}) begin
              state_d = ST_IDLE;
              cnt_d   = '0;
            end else begin
              ocnt_d = ocnt_nx[CNT_W-1:0];
            end
          end
        end
        default: ;  // ST_HOLD: latched until cleared
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ocnt_q  <= '0;
      sv_q    <= '0;
      tout_q  <= '0;
      rtsr_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ocnt_q  <= ocnt_d;
      sv_q    <= sv_d;
      tout_q  <= tout_d;
      rtsr_q  <= rtsr_d;
    end
  end

  assign running_o = (state_q == ST_RUN);
  assign out_o     = (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign pv_o      = count_down_i ? (sv_q - cnt_q) : cnt_q;

  assert_gate_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && gate_i && !rst_ok) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q)));
  assert_idle_tick_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !tick_i && !rst_ok) |=> (cnt_q == $past(cnt_q)));
  assert_reset_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ok |=> (!out_o && !running_o));
  assert_start_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && reset_i) |=> !running_o);
  assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !rst_ok) |=> out_o);
  assert_run_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o |-> (cnt_q < sv_q));
  assert_out_from_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_o) |-> $past(running_o));
endmodule

// File: tb/tb_on_delay_timer.sv
module tb_on_delay_timer;
  localparam int CNT_W = 16;
  localparam int RW_W  = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tick_i = 1'b1;
  logic             start_i = 1'b0;
  logic             gate_i = 1'b0;
  logic             reset_i = 1'b0;
  logic             count_down_i = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] width_i = '0;
  logic [RW_W-1:0]  rst_width_i = 8'd3;
  logic [CNT_W-1:0] pv_o;
  logic             running_o, out_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  on_delay_timer #(.CNT_W(CNT_W), .RW_W(RW_W)) dut (.*);

  always #4 clk_i = ~clk_i;

  // {period[8], width[8], down[1], gate_len[8]}
  localparam logic [24:0] VEC [6] = '{
    {8'd5,  8'd3, 1'b0, 8'd0},
    {8'd6,  8'd2, 1'b1, 8'd0},
    {8'd4,  8'd1, 1'b0, 8'd3},
    {8'd7,  8'd4, 1'b1, 8'd2},
    {8'd3,  8'd5, 1'b0, 8'd0},
    {8'd10, 8'd2, 1'b1, 8'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  // starts a period, measures delay and pulse width; tamper adds mid-run input changes
  task automatic run_vec(input int sv, input int tw, input bit dn, input int g, input bit tamper);
    int n, w;
    period_i = CNT_W'(sv);
    width_i = CNT_W'(tw);
    count_down_i = dn;
    start_i = 1'b1;
    cyc(1);
    start_i = 1'b0;
    chk(running_o === 1'b1, "R1 running after start", int'(running_o), 1);
    n = 0;
    while (!out_o && n < 300) begin
      cyc(1);
      n++;
      if (tamper && n == 1) begin
        period_i = 16'd50;
        width_i = 16'd9;
      end
      if (tamper && n == 2) start_i = 1'b1;
      if (tamper && n == 3) start_i = 1'b0;
      if (n == 2) begin
        chk(pv_o == (dn ? CNT_W'(sv - 2) : 16'd2), "R5 present value mid-run",
            int'(pv_o), dn ? sv - 2 : 2);
        if (g > 0) gate_i = 1'b1;
      end
      if (g > 0 && n == 2 + g) begin
        chk(pv_o == (dn ? CNT_W'(sv - 2) : 16'd2), "R6 value held under gate",
            int'(pv_o), dn ? sv - 2 : 2);
        gate_i = 1'b0;
      end
    end
    chk(n == sv + g, tamper ? "R11 R10 delay unchanged" : "R2 R6 on-delay", n, sv + g);
    w = 0;
    while (out_o && w < 300) begin
      cyc(1);
      w++;
    end
    chk(w == tw, tamper ? "R11 width unchanged" : "R3 pulse width", w, tw);
    count_down_i = 1'b0;
    #1;
    chk(!running_o && pv_o == '0, "R3 back to idle", int'(pv_o), 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    done = 1'b1;
  end

  initial begin
    cyc(2);
    chk(!out_o && !running_o && pv_o == '0, "R12 reset state", int'(out_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(1);

    foreach (VEC[i]) begin
      run_vec(int'(VEC[i][24:17]), int'(VEC[i][16:9]), VEC[i][8], int'(VEC[i][7:0]), 1'b0);
      cyc(2);
    end

    // R11 / R10: mid-run changes of params and a second start edge
    run_vec(8, 2, 1'b0, 0, 1'b1);
    cyc(2);

    // R4 latch, R8 short reset, R7 qualified reset, R9 start blocked
    period_i = 16'd3; width_i = 16'd0; rst_width_i = 8'd3;
    start_i = 1'b1; cyc(1); start_i = 1'b0;
    cyc(30);
    chk(out_o === 1'b1, "R4 latched output", int'(out_o), 1);
    chk(pv_o == 16'd3, "R5 elapsed at expiry", int'(pv_o), 3);
    reset_i = 1'b1; cyc(2); reset_i = 1'b0; cyc(3);
    chk(out_o === 1'b1, "R8 short reset ignored", int'(out_o), 1);
    start_i = 1'b1; cyc(2); start_i = 1'b0; cyc(2);
    chk(out_o === 1'b1 && !running_o, "R10 start ignored while on", int'(out_o), 1);
    reset_i = 1'b1; cyc(6);
    chk(out_o === 1'b0 && !running_o, "R7 qualified reset clears", int'(out_o), 0);
    chk(pv_o == '0, "R7 value cleared", int'(pv_o), 0);
    start_i = 1'b1; cyc(2);
    chk(running_o === 1'b0, "R9 start blocked under reset", int'(running_o), 0);
    start_i = 1'b0; cyc(1);
    reset_i = 1'b0; cyc(10);
    chk(!running_o && !out_o, "R9 no late start", int'(running_o), 0);

    // R7 clearing a running period
    period_i = 16'd40; width_i = 16'd2;
    start_i = 1'b1; cyc(1); start_i = 1'b0; cyc(5);
    reset_i = 1'b1; cyc(6); reset_i = 1'b0; cyc(1);
    chk(!running_o && pv_o == '0, "R7 period cleared", int'(pv_o), 0);

    // R13 sparse ticks
    period_i = 16'd3; width_i = 16'd1; tick_i = 1'b0;
    start_i = 1'b1; cyc(1); start_i = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      cyc(2);
      chk(!out_o && pv_o == CNT_W'(k - 1), "R13 no advance without tick", int'(pv_o), k - 1);
      tick_i = 1'b1; cyc(1); tick_i = 1'b0;
    end
    chk(out_o === 1'b1, "R13 expiry on third tick", int'(out_o), 1);
    tick_i = 1'b1; cyc(3);

    // R12 power-loss reset mid-run
    period_i = 16'd20; width_i = 16'd2;
    start_i = 1'b1; cyc(1); start_i = 1'b0; cyc(5);
    rst_ni = 1'b0; #1;
    chk(!running_o && !out_o && pv_o == '0, "R12 async clear", int'(running_o), 0);
    cyc(1); rst_ni = 1'b1; cyc(1);

    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule